// File: doc/BRIEF.md
# Seconds RTC with alarm

This block is a real-time seconds counter that sits on a simple single-cycle register bus. A one-cycle tick input advances a prescaler while counting is enabled. Each time the prescaler's most significant bit falls from 1 to 0, a seconds counter steps by one. A software write that clears that bit while it is set counts as a fall as well.

An alarm register is compared with the seconds counter at the moment the counter steps. The alarm flag rises when the counter leaves the alarm value, not when it arrives at it. A time-invalid flag comes up at reset and stays up until software loads the seconds counter. While that flag is up, counting cannot be started.

A level interrupt output is high while any flag is set together with its enable bit. A control bit decides whether non-privileged bus masters may write. Reads are combinational. Writes take effect at the clock edge.

Top module: `sec_rtc`

## Requirements
- R1: After reset, every register reads 0 except the status register, which reads 0x01 (time-invalid set), and irq_o is low.
- R2: Register offsets are: seconds 0x00, prescaler 0x04, alarm 0x08, control 0x10, status 0x14, interrupt enable 0x1C. A read returns the register value zero-extended in the same cycle, and the prescaler keeps only its low PRESC_W bits.
- R3: Writes to the seconds and prescaler registers are ignored while the run bit (status bit 4) is set.
- R4: While running, each cycle with tick_i high adds one to the prescaler. The prescaler wraps to 0 after all ones, and the seconds register steps by one on that wrap, which is once per 2^PRESC_W ticks.
- R5: An accepted prescaler write that clears the prescaler's top bit while that bit is 1 steps the seconds register by one.
- R6: Time-invalid (status bit 0) is cleared only by an accepted seconds write. While it is set, the run bit cannot be set and a prescaler top-bit fall does not step the seconds register.
- R7: The alarm flag (status bit 1) sets when the seconds register steps while it equals the alarm register. Stepping onto the alarm value does not set it.
- R8: Any accepted write to the alarm register clears the alarm flag.
- R9: irq_o is high while (time-invalid AND interrupt-enable bit 0) OR (alarm flag AND interrupt-enable bit 2).
- R10: A write with bus_priv_i low is ignored unless control bit 1 (user write permit) is set. Privileged writes are always accepted.
- R11: Status bits 0 and 1 are read-only, and a status write changes only the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle prescaler advance strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_priv_i | input | 1 | High for a privileged access |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with PRESC_W = 4 and SEC_W = 32. With that prescaler width, a seconds step takes 16 ticks instead of 32768. This puts the wrap step, the alarm-on-leave rule and the write-locked window within a few hundred cycles. The narrow prescaler also makes the top-bit write carry (bit 3 here) easy to set up, and it exercises the truncation of wide prescaler writes.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_SECS  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_PRESC = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_ALARM = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 5'h1C;

    localparam int STAT_INV_BIT  = 0;
    localparam int STAT_ALM_BIT  = 1;
    localparam int STAT_RUN_BIT  = 4;
    localparam int CTRL_USER_BIT = 1;
    localparam int IEN_INV_BIT   = 0;
    localparam int IEN_ALM_BIT   = 2;
endpackage

// File: rtl/sec_rtc_timebase.sv
module sec_rtc_timebase
    import sec_rtc_pkg::*;
#(
    parameter int PRESC_W = 15,
    parameter int SEC_W   = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               run_i,
    input  logic               hold_i,
    input  logic               presc_wr_i,
    input  logic               secs_wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [PRESC_W-1:0] presc_o,
    output logic [SEC_W-1:0]   secs_o,
    output logic               step_o
);
    localparam int               MSB     = PRESC_W - 1;
    localparam logic [PRESC_W-1:0] P_ONE = PRESC_W'(1);
    localparam logic [SEC_W-1:0]   S_ONE = SEC_W'(1);

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [SEC_W-1:0]   secs;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      step;

    always_comb begin
        st_d = st_q;
        if (presc_wr_i) begin
            st_d.presc = wdata_i[PRESC_W-1:0];
        end else if (run_i && tick_i) begin
            st_d.presc = st_q.presc + P_ONE;
        end
        step = st_q.presc[MSB] && !st_d.presc[MSB] && !hold_i;
        if (secs_wr_i) begin
            st_d.secs = wdata_i[SEC_W-1:0];
        end else if (step) begin
            st_d.secs = st_q.secs + S_ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign presc_o = st_q.presc;
    assign secs_o  = st_q.secs;
    assign step_o  = step;

    AST_WRAP_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && tick_i && !presc_wr_i && !secs_wr_i && (&st_q.presc))
        |=> (st_q.secs == $past(st_q.secs) + S_ONE)); // R4

    AST_WRITE_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (presc_wr_i && st_q.presc[MSB] && !wdata_i[MSB] && !hold_i && !secs_wr_i)
        |=> (st_q.secs == $past(st_q.secs) + S_ONE)); // R5

    AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hold_i && !secs_wr_i) |=> $stable(st_q.secs)); // R6
endmodule

// File: rtl/sec_rtc_status.sv
module sec_rtc_status
    import sec_rtc_pkg::*;
#(
    parameter int SEC_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [SEC_W-1:0] secs_i,
    input  logic [SEC_W-1:0] alarm_i,
    input  logic             secs_wr_i,
    input  logic             alarm_wr_i,
    input  logic             stat_wr_i,
    input  logic             run_wdata_i,
    input  logic             ien_inv_i,
    input  logic             ien_alm_i,
    output logic             inv_o,
    output logic             alm_o,
    output logic             run_o,
    output logic             irq_o
);
    typedef struct packed {
        logic inv;
        logic alm;
        logic run;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (secs_wr_i) begin
            st_d.inv = 1'b0;
        end
        if (step_i && (secs_i == alarm_i)) begin
            st_d.alm = 1'b1;
        end
        if (alarm_wr_i) begin
            st_d.alm = 1'b0;
        end
        if (stat_wr_i) begin
            st_d.run = run_wdata_i && !st_q.inv;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{inv: 1'b1, alm: 1'b0, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign inv_o = st_q.inv;
    assign alm_o = st_q.alm;
    assign run_o = st_q.run;
    assign irq_o = (st_q.inv && ien_inv_i) || (st_q.alm && ien_alm_i);

    AST_RUN_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.inv |-> !st_q.run); // R6

    AST_INV_STAYS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.inv |=> !st_q.inv); // R6

    AST_ALARM_ON_LEAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && (secs_i == alarm_i) && !alarm_wr_i) |=> st_q.alm); // R7

    AST_ALARM_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_wr_i |=> !st_q.alm); // R8
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int PRESC_W = 15,
    parameter int SEC_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic              bus_priv_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [SEC_W-1:0] alarm;
        logic             user_wr;
        logic             ien_inv;
        logic             ien_alm;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic               wr_ok;
    logic               secs_wr, presc_wr, alarm_wr, ctrl_wr, stat_wr, ien_wr;
    logic [PRESC_W-1:0] presc;
    logic [SEC_W-1:0]   secs;
    logic               step;
    logic               inv, alm, run;

    assign wr_ok    = bus_wr_i && (bus_priv_i || cfg_q.user_wr);
    assign secs_wr  = wr_ok && (bus_addr_i == OFS_SECS)  && !run;
    assign presc_wr = wr_ok && (bus_addr_i == OFS_PRESC) && !run;
    assign alarm_wr = wr_ok && (bus_addr_i == OFS_ALARM);
    assign ctrl_wr  = wr_ok && (bus_addr_i == OFS_CTRL);
    assign stat_wr  = wr_ok && (bus_addr_i == OFS_STAT);
    assign ien_wr   = wr_ok && (bus_addr_i == OFS_IEN);

    always_comb begin
        cfg_d = cfg_q;
        if (alarm_wr) cfg_d.alarm = bus_wdata_i[SEC_W-1:0];
        if (ctrl_wr)  cfg_d.user_wr = bus_wdata_i[CTRL_USER_BIT];
        if (ien_wr) begin
            cfg_d.ien_inv = bus_wdata_i[IEN_INV_BIT];
            cfg_d.ien_alm = bus_wdata_i[IEN_ALM_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    sec_rtc_timebase #(.PRESC_W(PRESC_W), .SEC_W(SEC_W)) u_timebase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .run_i      (run),
        .hold_i     (inv),
        .presc_wr_i (presc_wr),
        .secs_wr_i  (secs_wr),
        .wdata_i    (bus_wdata_i),
        .presc_o    (presc),
        .secs_o     (secs),
        .step_o     (step)
    );

    sec_rtc_status #(.SEC_W(SEC_W)) u_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_i      (step),
        .secs_i      (secs),
        .alarm_i     (cfg_q.alarm),
        .secs_wr_i   (secs_wr),
        .alarm_wr_i  (alarm_wr),
        .stat_wr_i   (stat_wr),
        .run_wdata_i (bus_wdata_i[STAT_RUN_BIT]),
        .ien_inv_i   (cfg_q.ien_inv),
        .ien_alm_i   (cfg_q.ien_alm),
        .inv_o       (inv),
        .alm_o       (alm),
        .run_o       (run),
        .irq_o       (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_SECS:  bus_rdata_o = DATA_W'(secs);
            OFS_PRESC: bus_rdata_o = DATA_W'(presc);
            OFS_ALARM: bus_rdata_o = DATA_W'(cfg_q.alarm);
            OFS_CTRL:  bus_rdata_o[CTRL_USER_BIT] = cfg_q.user_wr;
            OFS_STAT: begin
                bus_rdata_o[STAT_INV_BIT] = inv;
                bus_rdata_o[STAT_ALM_BIT] = alm;
                bus_rdata_o[STAT_RUN_BIT] = run;
            end
            OFS_IEN: begin
                bus_rdata_o[IEN_INV_BIT] = cfg_q.ien_inv;
                bus_rdata_o[IEN_ALM_BIT] = cfg_q.ien_alm;
            end
            default: bus_rdata_o = '0;
        endcase
    end

    AST_SECS_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == OFS_SECS) && run && !step) |=> $stable(secs)); // R3

    AST_PRESC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && (bus_addr_i == OFS_PRESC) && run && !tick_i) |=> $stable(presc)); // R3

    AST_USER_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !bus_priv_i && !cfg_q.user_wr)
        |=> ($stable(cfg_q) && $stable(run))); // R10
endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
    localparam int PW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        priv = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sec_rtc #(.PRESC_W(PW), .SEC_W(32)) u_sec_rtc (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .bus_wr_i(wr), .bus_priv_i(priv), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [4:0]  a;
        logic [31:0] d;
        logic        p;
        logic [31:0] e;
    } vec_t;

    // write a/d with privilege p, then read a back and expect e
    localparam vec_t VECS [10] = '{
        '{5'h08, 32'h1234_5678, 1'b1, 32'h1234_5678}, // R2 alarm
        '{5'h04, 32'h0000_0015, 1'b1, 32'h0000_0005}, // R2 prescaler truncation
        '{5'h1C, 32'h0000_0005, 1'b1, 32'h0000_0005}, // R2 enables
        '{5'h1C, 32'h0000_0000, 1'b0, 32'h0000_0005}, // R10 user write blocked
        '{5'h10, 32'h0000_0002, 1'b1, 32'h0000_0002}, // R10 permit user writes
        '{5'h1C, 32'h0000_0004, 1'b0, 32'h0000_0004}, // R10 user write accepted
        '{5'h10, 32'h0000_0000, 1'b0, 32'h0000_0000}, // R10 user revokes permit
        '{5'h14, 32'h0000_0010, 1'b1, 32'h0000_0001}, // R6 run refused while invalid
        '{5'h00, 32'h0000_0064, 1'b1, 32'h0000_0064}, // R6 seconds load
        '{5'h14, 32'h0000_0003, 1'b1, 32'h0000_0000}  // R11 flags read-only, R6 cleared
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d; priv = p;
        @(negedge clk);
        wr = 1'b0; priv = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        bus_read(5'h00, v); check("R1 seconds", v, 32'h0);
        bus_read(5'h04, v); check("R1 prescaler", v, 32'h0);
        bus_read(5'h08, v); check("R1 alarm", v, 32'h0);
        bus_read(5'h10, v); check("R1 control", v, 32'h0);
        bus_read(5'h14, v); check("R1 status", v, 32'h1);
        bus_read(5'h1C, v); check("R1 enables", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        for (int i = 0; i < 10; i++) begin
            bus_write(VECS[i].a, VECS[i].d, VECS[i].p);
            bus_read(VECS[i].a, v);
            check($sformatf("R2/R10 vector %0d", i), v, VECS[i].e);
        end

        // R5 software clear of the prescaler top bit steps seconds (100 -> 101)
        bus_write(5'h04, 32'h8, 1'b1);
        bus_write(5'h04, 32'h0, 1'b1);
        bus_read(5'h00, v); check("R5 seconds after carry", v, 32'd101);

        // R4 counting, R7 no flag on arriving at the alarm value
        bus_write(5'h08, 32'd102, 1'b1);
        bus_write(5'h14, 32'h10, 1'b1);
        bus_read(5'h14, v); check("R11 run bit set", v, 32'h10);
        ticks(15);
        bus_read(5'h04, v); check("R4 prescaler 15", v, 32'd15);
        bus_read(5'h00, v); check("R4 seconds before wrap", v, 32'd101);
        ticks(1);
        bus_read(5'h04, v); check("R4 prescaler wrapped", v, 32'd0);
        bus_read(5'h00, v); check("R4 seconds stepped", v, 32'd102);
        bus_read(5'h14, v); check("R7 no flag on arrival", v, 32'h10);
        check("R9 irq low", {31'h0, irq}, 32'h0);

        // R3 time registers locked while running
        bus_write(5'h00, 32'd5, 1'b1);
        bus_read(5'h00, v); check("R3 seconds locked", v, 32'd102);
        bus_write(5'h04, 32'd3, 1'b1);
        bus_read(5'h04, v); check("R3 prescaler locked", v, 32'd0);

        // R7 leaving the alarm value sets the flag, R9 irq
        ticks(16);
        bus_read(5'h00, v); check("R4 second step", v, 32'd103);
        bus_read(5'h14, v); check("R7 flag on leave", v, 32'h12);
        check("R9 irq alarm", {31'h0, irq}, 32'h1);
        bus_write(5'h1C, 32'h0, 1'b1);
        check("R9 irq masked", {31'h0, irq}, 32'h0);
        bus_write(5'h1C, 32'h4, 1'b1);
        check("R9 irq unmasked", {31'h0, irq}, 32'h1);

        // R8 alarm write clears the flag
        bus_write(5'h08, 32'hFFFF_FFFF, 1'b1);
        bus_read(5'h14, v); check("R8 flag cleared", v, 32'h10);
        check("R8 irq low", {31'h0, irq}, 32'h0);

        // stop counting: ticks have no effect
        bus_write(5'h14, 32'h0, 1'b1);
        bus_read(5'h04, v);
        begin
            logic [31:0] p0;
            p0 = v;
            ticks(20);
            bus_read(5'h04, v); check("R4 stopped prescaler holds", v, p0);
        end

        // R6 / R9 time-invalid path after a fresh reset
        do_reset();
        bus_write(5'h1C, 32'h1, 1'b1);
        check("R9 irq from invalid", {31'h0, irq}, 32'h1);
        bus_write(5'h04, 32'h8, 1'b1);
        bus_write(5'h04, 32'h0, 1'b1);
        bus_read(5'h00, v); check("R6 no carry while invalid", v, 32'd0);
        bus_write(5'h00, 32'd7, 1'b1);
        check("R6 irq drops on load", {31'h0, irq}, 32'h0);
        bus_read(5'h14, v); check("R6 invalid cleared", v, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule